// File: doc/BRIEF.md
# Accumulator Logic and Move Execute Unit

This block decodes and executes, in a single clock, four instructions of a small 8-bit accumulator machine that uses 12-bit instruction words. It holds the working register W, a zero status flag and a 32-entry file of 8-bit registers. It can OR an 8-bit literal into W. It can load a literal into W. It can OR W with a chosen file register. It can move a file register. The two file-register forms carry a destination bit: the result goes either to W or back into the addressed file entry.

An instruction is presented on `instr` with `instrValid` high and takes effect at that rising edge. Fetch, sequencing and every other opcode belong to the surrounding machine. A separate load port lets that machine fill file entries. The file is not cleared by reset, so it must be filled before anything reads it.

Top module: `accum_exec_unit`

## Requirements
- R1: With instr[11:8] = 4'b1101, W becomes W OR instr[7:0], and the zero flag becomes 1 exactly when that result is 8'h00.
- R2: With instr[11:8] = 4'b1100, W becomes instr[7:0] and the zero flag keeps its previous value.
- R3: With instr[11:6] = 6'b000100, the result is W OR file[instr[4:0]]. The destination bit instr[5] = 0 writes the result to W and leaves the file entry alone. instr[5] = 1 writes the result to the file entry and leaves W alone.
- R4: With instr[11:6] = 6'b001000, the result is file[instr[4:0]] unchanged. It goes to W when instr[5] = 0 and back to the same entry when instr[5] = 1.
- R5: For the forms in R3 and R4, the zero flag is set when the result is 8'h00 and cleared otherwise, whichever destination is chosen.
- R6: An instruction word matching none of the four patterns, or any word presented with instrValid low, leaves W, the zero flag and every file entry unchanged.
- R7: Each instruction completes at the rising edge where instrValid is sampled high, and an instruction in the next cycle sees that result.
- R8: A synchronous active-high reset sets W to 8'h00 and the zero flag to 0, and leaves file contents as they were.
- R9: When fileLoadEn is high at a rising edge, fileLoadData is written to entry fileLoadAddr. If an executing instruction writes the file in the same cycle, the instruction's write is performed and the load is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instrValid | input | 1 | Execute `instr` at this edge |
| instr | input | 12 | Instruction word |
| fileLoadEn | input | 1 | Write strobe of the file load port |
| fileLoadAddr | input | 5 | File entry to load |
| fileLoadData | input | 8 | Value to load |
| wReg | output | 8 | Working register |
| zeroFlag | output | 1 | Zero status flag |

## Verification
A wrong W or zero flag appears on `wReg` or `zeroFlag` in the cycle right after the faulty instruction, because both are registered outputs. A wrong file entry shows nothing at the ports until an instruction later reads that entry. For this reason the sweep runs every one of the 4096 instruction words against a model, and it then reads each of the 32 entries back into W with a move. A decode fault that writes the file when it should not therefore appears at the latest in that final read-back.

// File: rtl/accum_pkg.sv
package accum_pkg;
  localparam int INSTR_W = 12;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;
  localparam int FILE_DEPTH = 1 << ADDR_W;

  localparam logic [3:0] OPC_OR_LIT = 4'b1101;
  localparam logic [3:0] OPC_LOAD_LIT = 4'b1100;
  localparam logic [5:0] OPC_OR_FILE = 6'b000100;
  localparam logic [5:0] OPC_MOVE_FILE = 6'b001000;

  typedef enum logic [1:0] {
    SRC_LIT,
    SRC_OR_LIT,
    SRC_OR_FILE,
    SRC_FILE
  } aluSrc_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_OR_LIT,
    OP_LOAD_LIT,
    OP_OR_FILE,
    OP_MOVE_FILE
  } opKind_e;

  typedef struct packed {
    logic    loadW;
    logic    loadF;
    logic    loadZ;
    aluSrc_e aluSrc;
  } execCtrl_t;
endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
#(
  parameter int INSTR_BITS = INSTR_W,
  parameter int DATA_BITS = DATA_W,
  parameter int ADDR_BITS = ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  instrValid,
  input  logic [INSTR_BITS-1:0] instr,
  output execCtrl_t             ctrl,
  output logic [DATA_BITS-1:0]  literal,
  output logic [ADDR_BITS-1:0]  fileAddr
);
  localparam int DEST_BIT = ADDR_BITS;
  localparam int TOP_HI = INSTR_BITS - 1;

  opKind_e opKind;
  logic destFile;

  assign literal  = instr[DATA_BITS-1:0];
  assign fileAddr = instr[ADDR_BITS-1:0];
  assign destFile = instr[DEST_BIT];

  always_comb begin
    opKind = OP_NONE;
    if (instr[TOP_HI -: 4] == OPC_OR_LIT) begin
      opKind = OP_OR_LIT;
    end else if (instr[TOP_HI -: 4] == OPC_LOAD_LIT) begin
      opKind = OP_LOAD_LIT;
    end else if (instr[TOP_HI -: 6] == OPC_OR_FILE) begin
      opKind = OP_OR_FILE;
    end else if (instr[TOP_HI -: 6] == OPC_MOVE_FILE) begin
      opKind = OP_MOVE_FILE;
    end
  end

  always_comb begin
    ctrl = '{loadW: 1'b0, loadF: 1'b0, loadZ: 1'b0, aluSrc: SRC_LIT};
    if (instrValid) begin
      unique case (opKind)
        OP_OR_LIT: begin
          ctrl.aluSrc = SRC_OR_LIT;
          ctrl.loadW  = 1'b1;
          ctrl.loadZ  = 1'b1;
        end
        OP_LOAD_LIT: begin
          ctrl.aluSrc = SRC_LIT;
          ctrl.loadW  = 1'b1;
        end
        OP_OR_FILE: begin
          ctrl.aluSrc = SRC_OR_FILE;
          ctrl.loadW  = ~destFile;
          ctrl.loadF  = destFile;
          ctrl.loadZ  = 1'b1;
        end
        OP_MOVE_FILE: begin
          ctrl.aluSrc = SRC_FILE;
          ctrl.loadW  = ~destFile;
          ctrl.loadF  = destFile;
          ctrl.loadZ  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R3 R4: a result never goes to both destinations
  a_r3_single_dest: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.loadW, ctrl.loadF}));

  // R6: no strobe leaves the decoder without a valid instruction
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !instrValid |-> !(ctrl.loadW || ctrl.loadF || ctrl.loadZ));
endmodule

// File: rtl/accum_datapath.sv
module accum_datapath
  import accum_pkg::*;
#(
  parameter int DATA_BITS = DATA_W,
  parameter int ADDR_BITS = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  execCtrl_t            ctrl,
  input  logic [DATA_BITS-1:0] literal,
  input  logic [ADDR_BITS-1:0] fileAddr,
  input  logic                 fileLoadEn,
  input  logic [ADDR_BITS-1:0] fileLoadAddr,
  input  logic [DATA_BITS-1:0] fileLoadData,
  output logic [DATA_BITS-1:0] wReg,
  output logic                 zeroFlag
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [DATA_BITS-1:0] fileMem [DEPTH];
  logic [DATA_BITS-1:0] fileRead;
  logic [DATA_BITS-1:0] aluResult;
  logic [DATA_BITS-1:0] wrData;
  logic [ADDR_BITS-1:0] wrAddr;
  logic                 wrEn;

  assign fileRead = fileMem[fileAddr];

  always_comb begin
    unique case (ctrl.aluSrc)
      SRC_LIT:     aluResult = literal;
      SRC_OR_LIT:  aluResult = wReg | literal;
      SRC_OR_FILE: aluResult = wReg | fileRead;
      SRC_FILE:    aluResult = fileRead;
      default:     aluResult = literal;
    endcase
  end

  // single write port: the executing instruction has priority over the load port
  always_comb begin
    wrEn   = ctrl.loadF | fileLoadEn;
    wrAddr = ctrl.loadF ? fileAddr : fileLoadAddr;
    wrData = ctrl.loadF ? aluResult : fileLoadData;
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      fileMem[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wReg     <= '0;
      zeroFlag <= 1'b0;
    end else begin
      if (ctrl.loadW) begin
        wReg <= aluResult;
      end
      if (ctrl.loadZ) begin
        zeroFlag <= (aluResult == '0);
      end
    end
  end

  // R8: reset clears W and the flag
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (wReg == '0 && !zeroFlag));

  // R6: W holds whenever it is not a destination
  a_r6_w_holds: assert property (@(posedge clk) disable iff (rst)
    !ctrl.loadW |=> $stable(wReg));

  // R2: flag holds for operations that do not update it
  a_r2_z_holds: assert property (@(posedge clk) disable iff (rst)
    !ctrl.loadZ |=> $stable(zeroFlag));

  // R5: flag reflects the result of the last updating instruction
  a_r5_z_tracks: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadZ |=> (zeroFlag == ($past(aluResult) == '0)));
endmodule

// File: rtl/accum_exec_unit.sv
module accum_exec_unit
  import accum_pkg::*;
#(
  parameter int DATA_BITS = DATA_W,
  parameter int ADDR_BITS = ADDR_W,
  parameter int INSTR_BITS = INSTR_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  instrValid,
  input  logic [INSTR_BITS-1:0] instr,
  input  logic                  fileLoadEn,
  input  logic [ADDR_BITS-1:0]  fileLoadAddr,
  input  logic [DATA_BITS-1:0]  fileLoadData,
  output logic [DATA_BITS-1:0]  wReg,
  output logic                  zeroFlag
);
  execCtrl_t            ctrl;
  logic [DATA_BITS-1:0] literal;
  logic [ADDR_BITS-1:0] fileAddr;

  accum_ctrl #(
    .INSTR_BITS(INSTR_BITS),
    .DATA_BITS (DATA_BITS),
    .ADDR_BITS (ADDR_BITS)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .instrValid(instrValid),
    .instr     (instr),
    .ctrl      (ctrl),
    .literal   (literal),
    .fileAddr  (fileAddr)
  );

  accum_datapath #(
    .DATA_BITS(DATA_BITS),
    .ADDR_BITS(ADDR_BITS)
  ) i_datapath (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .literal     (literal),
    .fileAddr    (fileAddr),
    .fileLoadEn  (fileLoadEn),
    .fileLoadAddr(fileLoadAddr),
    .fileLoadData(fileLoadData),
    .wReg        (wReg),
    .zeroFlag    (zeroFlag)
  );
endmodule

// File: tb/test_accum_exec_unit.sv
module test_accum_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [11:0] instr = '0;
  logic        fileLoadEn = 1'b0;
  logic [4:0]  fileLoadAddr = '0;
  logic [7:0]  fileLoadData = '0;
  logic [7:0]  wReg;
  logic        zeroFlag;

  int total = 0;
  int bad = 0;
  logic [7:0] mW;
  logic       mZ;
  logic [7:0] mMem [32];

  always #10 clk = ~clk;

  accum_exec_unit i_accum_exec_unit (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instr(instr),
    .fileLoadEn(fileLoadEn), .fileLoadAddr(fileLoadAddr),
    .fileLoadData(fileLoadData), .wReg(wReg), .zeroFlag(zeroFlag)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [11:0] ins);
    if (ins[11:8] == 4'b1101) return "R1";
    if (ins[11:8] == 4'b1100) return "R2";
    if (ins[11:6] == 6'b000100) return "R3";
    if (ins[11:6] == 6'b001000) return "R4";
    return "R6";
  endfunction

  task automatic modelExec(input logic [11:0] ins);
    logic [7:0] res;
    if (ins[11:8] == 4'b1101) begin
      res = mW | ins[7:0]; mW = res; mZ = (res == 0);
    end else if (ins[11:8] == 4'b1100) begin
      mW = ins[7:0];
    end else if (ins[11:6] == 6'b000100 || ins[11:6] == 6'b001000) begin
      res = (ins[11:6] == 6'b000100) ? (mW | mMem[ins[4:0]]) : mMem[ins[4:0]];
      if (ins[5]) mMem[ins[4:0]] = res; else mW = res;
      mZ = (res == 0);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic runInstr(input logic [11:0] ins);
    instr = ins; instrValid = 1'b1;
    @(negedge clk);
    instrValid = 1'b0;
    modelExec(ins);
  endtask

  task automatic loadFile(input logic [4:0] a, input logic [7:0] d);
    fileLoadEn = 1'b1; fileLoadAddr = a; fileLoadData = d;
    @(negedge clk);
    fileLoadEn = 1'b0;
    mMem[a] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mW = 0; mZ = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R8 reset W", wReg, 8'h00);
    check("R8 reset Z", {7'd0, zeroFlag}, 8'h00);

    for (int a = 0; a < 32; a++) loadFile(a[4:0], (a == 7) ? 8'h00 : 8'((a * 29 + 3) & 255));

    // examples and flag behaviour
    runInstr({4'b1100, 8'h9A});
    runInstr({4'b1101, 8'h35});
    check("R1 or literal W", wReg, 8'hBF);
    check("R1 or literal Z", {7'd0, zeroFlag}, 8'h00);
    loadFile(5'd5, 8'h13);
    runInstr({4'b1100, 8'h91});
    runInstr({6'b000100, 1'b0, 5'd5});
    check("R3 or file d0 W", wReg, 8'h93);
    check("R3 or file d0 Z", {7'd0, zeroFlag}, 8'h00);
    runInstr({6'b001000, 1'b0, 5'd5});
    check("R3 file untouched", wReg, 8'h13);
    runInstr({4'b1100, 8'h00});
    runInstr({4'b1101, 8'h00});
    check("R5 zero result sets Z", {7'd0, zeroFlag}, 8'h01);
    runInstr({4'b1100, 8'h55});
    check("R2 load keeps Z", {7'd0, zeroFlag}, 8'h01);
    check("R2 load W", wReg, 8'h55);

    // R7 back to back
    runInstr({4'b1100, 8'h01});
    runInstr({4'b1101, 8'h02});
    check("R7 chained first", wReg, 8'h03);
    runInstr({4'b1101, 8'h04});
    check("R7 chained second", wReg, 8'h07);

    // R6 valid low
    instr = {4'b1100, 8'hEE}; instrValid = 1'b0;
    @(negedge clk);
    check("R6 valid low W", wReg, 8'h07);

    // R4 move d1 of a zero entry
    runInstr({4'b1100, 8'h21});
    runInstr({6'b001000, 1'b1, 5'd7});
    check("R4 move d1 Z", {7'd0, zeroFlag}, 8'h01);
    check("R4 move d1 W kept", wReg, 8'h21);

    // R9 collision: instruction writes entry 10, load targets entry 9
    loadFile(5'd9, 8'h11);
    loadFile(5'd10, 8'h40);
    runInstr({4'b1100, 8'h02});
    instr = {6'b000100, 1'b1, 5'd10}; instrValid = 1'b1;
    fileLoadEn = 1'b1; fileLoadAddr = 5'd9; fileLoadData = 8'h77;
    @(negedge clk);
    instrValid = 1'b0; fileLoadEn = 1'b0;
    modelExec({6'b000100, 1'b1, 5'd10});
    runInstr({6'b001000, 1'b0, 5'd9});
    check("R9 load dropped", wReg, 8'h11);
    runInstr({6'b001000, 1'b0, 5'd10});
    check("R9 instruction write", wReg, 8'h42);

    // R8 reset keeps file
    loadFile(5'd3, 8'hA5);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mW = 0; mZ = 0;
    check("R8 reset W again", wReg, 8'h00);
    runInstr({6'b001000, 1'b0, 5'd3});
    check("R8 file survives reset", wReg, 8'hA5);

    // sweep every instruction word against the model
    for (int i = 0; i < 4096; i++) begin
      logic [7:0] seed;
      seed = (i % 5 == 0) ? 8'h00 : 8'((i * 37 + 11) & 255);
      runInstr({4'b1100, seed});
      runInstr(i[11:0]);
      check({tagOf(i[11:0]), " sweep W"}, wReg, mW);
      check({tagOf(i[11:0]), " sweep Z R5"}, {7'd0, zeroFlag}, {7'd0, mZ});
    end
    for (int a = 0; a < 32; a++) begin
      runInstr({6'b001000, 1'b0, a[4:0]});
      check("R4 R6 file readback", wReg, mMem[a]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule